// File: doc/BRIEF.md
# Parallel-Bus Converter Sequencer

This block runs an external eight-channel, eight-bit conversion chip that has a parallel data bus and a tri-state output. It works through one cycle after another without stopping. Each cycle samples the requested channel number and places it on the address lines. It strobes the address latch and then the start line. It then waits for the chip's end-of-conversion flag to fall and rise again. Last, it enables the chip's outputs for two clocks and copies the result byte into a holding register. That register drives eight indicator outputs directly.

The end-of-conversion flag comes in asynchronously, so it passes through a two-stage synchronizer first. If the flag never falls after a start, a 16-clock timeout keeps the sequencer from waiting forever. Each new result comes with a one-clock valid pulse. Clearing is asynchronous and active low. The intended clock is about 10 kHz.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While clr_n is low, and right after it falls with no clock edge, adc_ale, adc_start, adc_oe and sample_vld are 0, sample_q is 0 and adc_addr holds channel 1 (3'b001).
- R2: ch_sel is copied to adc_addr only on the clock edge that enters the set-address step. A change of ch_sel after that edge does not reach adc_addr before the next round.
- R3: adc_ale is high for exactly one clock. adc_addr has already held its value for one clock when adc_ale rises. adc_start rises in the clock right after adc_ale and never overlaps it.
- R4: adc_start is high for exactly one clock per conversion.
- R5: After start, the sequencer waits for the synchronized flag to go low and then high. When eoc rises while the sequencer is waiting, adc_oe rises three clocks later. adc_oe stays low until then.
- R6: If the synchronized flag is not seen low within 16 clocks of waiting, the sequencer moves on to wait for it high. With eoc held high, adc_oe rises 19 clocks after the clock in which adc_start is high.
- R7: adc_oe is high for exactly two clocks. The bus is captured at the end of the first of them. In the second, sample_vld is 1 and sample_q shows the new byte. Both drop in the following clock.
- R8: sample_q changes only in the clock where sample_vld is high. It holds its value through the whole conversion.
- R9: The sequence repeats without pause: adc_ale rises again two clocks after adc_oe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ch_sel | input | 3 | Requested channel number |
| eoc | input | 1 | End-of-conversion flag from the chip (asynchronous) |
| conv_data | input | 8 | Chip data bus |
| adc_addr | output | 3 | Channel address to the chip |
| adc_ale | output | 1 | Address latch strobe |
| adc_start | output | 1 | Conversion start strobe |
| adc_oe | output | 1 | Output enable for the chip's tri-state bus |
| sample_q | output | 8 | Held result byte driving the indicators |
| sample_vld | output | 1 | One-clock pulse marking a new result |

## Verification
The timeout path is the hardest to reach, because it needs a chip that never answers a start. The stimulus gets there by holding eoc high through a whole round and counting clocks from the start strobe to the output enable. Ignored channel changes are provoked by moving ch_sel just after each start. The bench models the tri-state bus by driving the inverted byte whenever adc_oe is low, so a capture taken outside the enable window shows up as a wrong byte.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Sequencer steps; order follows the handshake with the converter
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SET_ADDR,
        ST_ALE,
        ST_START,
        ST_START_LO,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_OE_ON,
        ST_CAPTURE,
        ST_OE_OFF
    } seq_state_e;

endpackage

// File: rtl/adc_seq_eoc_sync.sv
module adc_seq_eoc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_LEVEL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    // Counts clocks spent in the waiting step; cleared whenever it is left
    always_comb begin
        if (!run)                cnt_d = '0;
        else if (cnt_q == LAST)  cnt_d = cnt_q;
        else                     cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/adc_seq_hold.sv
module adc_seq_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] data_out,
    output logic              fresh
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fresh;
    } hold_t;

    hold_t hold_d;
    hold_t hold_q;

    always_comb begin
        hold_d       = hold_q;
        hold_d.fresh = load;
        if (load) hold_d.data = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign data_out = hold_q.data;
    assign fresh    = hold_q.fresh;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int EOC_TIMEOUT = 16,
    parameter int DEFAULT_CH  = 1
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] ch_sel,
    input  logic              eoc,
    input  logic [DATA_W-1:0] conv_data,
    output logic [ADDR_W-1:0] adc_addr,
    output logic              adc_ale,
    output logic              adc_start,
    output logic              adc_oe,
    output logic [DATA_W-1:0] sample_q,
    output logic              sample_vld
);

    import adc_seq_pkg::*;

    localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(DEFAULT_CH);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic eoc_s;
    logic tmo_hit;
    logic in_wait_lo;
    logic grab;

    adc_seq_eoc_sync #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (1'b1)
    ) i_sync (
        .clk      (clk),
        .rst_n    (clr_n),
        .async_in (eoc),
        .sync_out (eoc_s)
    );

    assign in_wait_lo = (seq_q.state == ST_WAIT_LO);

    adc_seq_timer #(
        .LIMIT (EOC_TIMEOUT)
    ) i_timer (
        .clk     (clk),
        .rst_n   (clr_n),
        .run     (in_wait_lo),
        .expired (tmo_hit)
    );

    // Capture on the edge leaving the first enable cycle
    assign grab = (seq_q.state == ST_OE_ON);

    adc_seq_hold #(
        .DATA_W (DATA_W)
    ) i_hold (
        .clk      (clk),
        .rst_n    (clr_n),
        .load     (grab),
        .bus_in   (conv_data),
        .data_out (sample_q),
        .fresh    (sample_vld)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE:     seq_d.state = ST_SET_ADDR;
            ST_SET_ADDR: seq_d.state = ST_ALE;
            ST_ALE:      seq_d.state = ST_START;
            ST_START:    seq_d.state = ST_START_LO;
            ST_START_LO: seq_d.state = ST_WAIT_LO;
            ST_WAIT_LO: begin
                if (!eoc_s || tmo_hit) seq_d.state = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (eoc_s) seq_d.state = ST_OE_ON;
            end
            ST_OE_ON:    seq_d.state = ST_CAPTURE;
            ST_CAPTURE:  seq_d.state = ST_OE_OFF;
            ST_OE_OFF:   seq_d.state = ST_SET_ADDR;
            default:     seq_d.state = ST_IDLE;
        endcase
        // Channel is taken only when entering the set-address step,
        // so the address is settled a full clock ahead of the latch strobe
        if (seq_d.state == ST_SET_ADDR && seq_q.state != ST_SET_ADDR)
            seq_d.addr = ch_sel;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.addr  <= RST_ADDR;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign adc_addr  = seq_q.addr;
    assign adc_ale   = (seq_q.state == ST_ALE);
    assign adc_start = (seq_q.state == ST_START);
    assign adc_oe    = (seq_q.state == ST_OE_ON) || (seq_q.state == ST_CAPTURE);

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              eoc_s,
    input logic [ADDR_W-1:0] adc_addr,
    input logic              adc_ale,
    input logic              adc_start,
    input logic              adc_oe,
    input logic [DATA_W-1:0] sample_q,
    input logic              sample_vld
);

    // R3: strobes never overlap
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!clr_n)
        $onehot0({adc_ale, adc_start, adc_oe}));

    // R3: address settled while latched
    a_r3_addr_settled: assert property (@(posedge clk) disable iff (!clr_n)
        adc_ale |-> $stable(adc_addr));

    // R3: start follows latch strobe
    a_r3_start_after_ale: assert property (@(posedge clk) disable iff (!clr_n)
        adc_ale |=> (adc_start && !adc_ale));

    // R4: single-clock start
    a_r4_start_single: assert property (@(posedge clk) disable iff (!clr_n)
        adc_start |=> !adc_start);

    // R2: address held during conversion and read-out
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!clr_n)
        (adc_start || adc_oe) |-> $stable(adc_addr));

    // R5: output enable opens only after synchronized flag was high
    a_r5_oe_after_eoc: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(adc_oe) |-> $past(eoc_s));

    // R7: valid pulse lasts one clock and sits inside the enable window
    a_r7_vld_single: assert property (@(posedge clk) disable iff (!clr_n)
        sample_vld |=> !sample_vld);

    a_r7_vld_in_oe: assert property (@(posedge clk) disable iff (!clr_n)
        sample_vld |-> adc_oe);

    // R8: held byte moves only with the valid pulse
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!clr_n)
        !$stable(sample_q) |-> sample_vld);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk        (clk),
    .clr_n      (clr_n),
    .eoc_s      (eoc_s),
    .adc_addr   (adc_addr),
    .adc_ale    (adc_ale),
    .adc_start  (adc_start),
    .adc_oe     (adc_oe),
    .sample_q   (sample_q),
    .sample_vld (sample_vld)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;
    localparam int NVEC       = 6;

    // Fields: [24] timeout mode, [23:21] channel, [20:18] mid-run channel,
    //         [17:10] result byte, [9:6] delay before eoc falls, [5:0] low length
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 3'd1, 3'd1, 8'h3C, 4'd1, 6'd4},
        {1'b0, 3'd5, 3'd2, 8'hFF, 4'd0, 6'd3},
        {1'b0, 3'd7, 3'd0, 8'h00, 4'd3, 6'd8},
        {1'b1, 3'd2, 3'd6, 8'h81, 4'd0, 6'd0},
        {1'b0, 3'd0, 3'd7, 8'h5A, 4'd5, 6'd20},
        {1'b0, 3'd4, 3'd3, 8'hC3, 4'd2, 6'd5}
    };

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [2:0] ch_sel = 3'd1;
    logic       eoc = 1'b1;
    logic [7:0] model_val = 8'h00;
    logic [7:0] conv_data;
    logic [2:0] adc_addr;
    logic       adc_ale, adc_start, adc_oe, sample_vld;
    logic [7:0] sample_q;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [7:0] last_data = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tri-state bus model: wrong byte whenever the enable is off
    assign conv_data = adc_oe ? model_val : ~model_val;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk        (clk),
        .clr_n      (clr_n),
        .ch_sel     (ch_sel),
        .eoc        (eoc),
        .conv_data  (conv_data),
        .adc_addr   (adc_addr),
        .adc_ale    (adc_ale),
        .adc_start  (adc_start),
        .adc_oe     (adc_oe),
        .sample_q   (sample_q),
        .sample_vld (sample_vld)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WDOG_LIMIT);
            finish_run();
        end
    end

    task automatic wait_ale();
        for (int i = 0; i < 60 && !adc_ale; i++) @(negedge clk);
        chk(adc_ale == 1'b1, "R9", "ale reached", adc_ale, 1);
    endtask

    // Entered at the negedge where adc_ale is high; leaves at the negedge
    // of the clock after the valid pulse (enable off)
    task automatic run_conv(input bit tmo, input logic [2:0] ch, input logic [2:0] mid,
                            input logic [7:0] data, input int dly, input int len);
        chk(adc_addr == ch, "R2", "addr at latch", adc_addr, ch);
        chk(adc_start == 1'b0, "R3", "no start with ale", adc_start, 0);
        @(negedge clk);
        chk(!adc_ale && adc_start, "R3", "start after ale", {adc_ale, adc_start}, 2'b01);
        @(negedge clk);
        chk(adc_start == 1'b0, "R4", "start one clock", adc_start, 0);
        ch_sel = mid;
        model_val = data;
        if (!tmo) begin
            repeat (dly) @(negedge clk);
            eoc = 1'b0;
            repeat (len) @(negedge clk);
            chk(adc_oe == 1'b0, "R5", "oe low while busy", adc_oe, 0);
            chk(sample_q == last_data, "R8", "held during conversion", sample_q, last_data);
            eoc = 1'b1;
            for (int i = 1; i <= 3; i++) begin
                @(negedge clk);
                chk(adc_oe == (i == 3), "R5", "oe latency", adc_oe, (i == 3));
            end
        end else begin
            int k = 1;
            while (!adc_oe && k < 40) begin
                @(negedge clk);
                k++;
            end
            chk(k == 19, "R6", "timeout start-to-oe clocks", k, 19);
        end
        chk(!sample_vld && sample_q == last_data, "R8", "no early capture", sample_q, last_data);
        chk(adc_addr == ch, "R2", "mid-run change ignored", adc_addr, ch);
        @(negedge clk);
        chk(adc_oe && sample_vld, "R7", "second oe clock valid", {adc_oe, sample_vld}, 2'b11);
        chk(sample_q == data, "R7", "captured byte", sample_q, data);
        @(negedge clk);
        chk(!adc_oe && !sample_vld, "R7", "oe and valid drop", {adc_oe, sample_vld}, 0);
        chk(sample_q == data, "R8", "byte held", sample_q, data);
        last_data = data;
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        chk(adc_addr == 3'd1, "R1", "reset addr", adc_addr, 1);
        chk({adc_ale, adc_start, adc_oe, sample_vld} == 4'b0, "R1", "reset strobes",
            {adc_ale, adc_start, adc_oe, sample_vld}, 0);
        chk(sample_q == 8'h00, "R1", "reset data", sample_q, 0);
        @(negedge clk);
        ch_sel = VEC[0][23:21];
        clr_n = 1'b1;
        wait_ale();
        for (int v = 0; v < NVEC; v++) begin
            run_conv(VEC[v][24], VEC[v][23:21], VEC[v][20:18], VEC[v][17:10],
                     int'(VEC[v][9:6]), int'(VEC[v][5:0]));
            if (v + 1 < NVEC) begin
                ch_sel = VEC[v+1][23:21];
                @(negedge clk);
                chk(!adc_ale && adc_addr == VEC[v+1][23:21], "R2", "new channel loaded",
                    adc_addr, VEC[v+1][23:21]);
                @(negedge clk);
                chk(adc_ale == 1'b1, "R9", "ale two clocks after oe", adc_ale, 1);
            end
        end

        // Clear in the middle of a conversion
        ch_sel = 3'd6;
        for (int i = 0; i < 60 && !adc_start; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        chk(adc_addr == 3'd1, "R1", "async clear addr", adc_addr, 1);
        chk({adc_ale, adc_start, adc_oe, sample_vld} == 4'b0, "R1", "async clear strobes",
            {adc_ale, adc_start, adc_oe, sample_vld}, 0);
        chk(sample_q == 8'h00, "R1", "async clear data", sample_q, 0);
        last_data = 8'h00;
        @(negedge clk);
        ch_sel = 3'd3;
        clr_n = 1'b1;
        wait_ale();
        run_conv(1'b0, 3'd3, 3'd5, 8'h96, 2, 6);
        finish_run();
    end

endmodule